// File: doc/BRIEF.md
# Internal Data Port Burst Master

This block is the bus-side engine that carries out register and memory accesses on a simple internal parallel data port. The port has a 16-bit address, separate one-cycle read and write strobes, and 32-bit data in each direction. A request decoder upstream hands over one request at a time. Each request carries a direction, a start address, a word count and an address mode. The master then issues one strobe per word and waits for the slave's verdict on that word.

For each word the slave answers with one of four outcomes: completion (data-ready for a read, write-acknowledge for a write), a no-more-data end, an unknown-address reject, or silence. Silence ends in a 32-cycle watchdog expiry, so a missing or hung slave can never stall the master. Each word's outcome is reported upstream. A single completion pulse ends every request and gives the final status and the number of words that completed. A no-more-data or unknown-address answer ends the burst early, and the master is at once ready for a new request, so the same access can be retried.

Top module: `dport_burst_master`

## Requirements
- R1: Each word produces exactly one strobe, one cycle wide: `bus_rd` for a read request and `bus_wr` for a write request, never both. `bus_addr` is valid during the strobe, and for writes so is `bus_wdata`. For each write word, `bus_wdata` is the `req_wdata` value present on the clock edge that raises the strobe.
- R2: A read word completes only on `bus_dready`, and its `bus_rdata` is captured into `word_rdata`. A write word completes only on `bus_wack`. The completion signal of the other direction is ignored, so such a word runs into the watchdog.
- R3: A `bus_nomore` answer ends the request with word and final status 1 (no more data), and `req_ready` returns so the access can be retried.
- R4: A `bus_unknown` answer ends the request with word and final status 2 (unknown address), and the master is ready for the next request.
- R5: If no valid answer is sampled on any of the 32 clock edges after the strobe cycle, `bus_timeout` pulses for one cycle, 32 cycles after the strobe cycle, and the request ends with status 3. An answer sampled on the 32nd edge still counts.
- R6: `req_len[14:0]` gives the number of words. When every word completes, exactly that many strobes are issued and the request ends with status 0 (done).
- R7: `req_len[15]` = 0 keeps `bus_addr` at the start address for every word. `req_len[15]` = 1 adds one after each completed word, wrapping modulo 2^16.
- R8: On an early end, `done_count` equals the number of words that completed before the failing word, and `word_valid` fires once for every strobe issued.
- R9: A word count of zero issues no strobe. `done` then pulses in the cycle after acceptance with status 0 and count 0.
- R10: After reset, `req_ready` is high and `bus_rd`, `bus_wr`, `done` and `bus_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered; taken while req_ready is high |
| req_ready | output | 1 | Master idle and able to take a request |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 16 | Start address |
| req_len | input | 16 | [14:0] word count, [15] address increment enable |
| req_wdata | input | 32 | Write data for the next word to be strobed |
| bus_addr | output | 16 | Data port address |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_wdata | output | 32 | Data port write data |
| bus_rdata | input | 32 | Data port read data |
| bus_dready | input | 1 | Slave: read data valid |
| bus_wack | input | 1 | Slave: write accepted |
| bus_nomore | input | 1 | Slave: busy or no more data |
| bus_unknown | input | 1 | Slave: address not decoded |
| bus_timeout | output | 1 | Watchdog expired, word abandoned |
| word_valid | output | 1 | One word resolved |
| word_status | output | 2 | 0 done, 1 no more data, 2 unknown, 3 timeout |
| word_rdata | output | 32 | Read data of the resolved word |
| done | output | 1 | Request finished |
| done_status | output | 2 | Final status, same coding as word_status |
| done_count | output | 15 | Words that completed |

## Verification
The bench places answers on the watchdog boundary. A reply on the 32nd edge must still complete, and a design with an off-by-one watchdog would either abandon that word or let a silent word run a cycle long. It sends the wrong completion signal for the direction, which a design that ORs the two signals would accept as success. It ends bursts early part-way through with no-more-data and unknown-address answers, which expose a wrong word count or a missing return to idle. Bursts with zero length, held addresses and addresses that wrap at the top of the space check the strobe count and the address sequence.

// File: rtl/dport_pkg.sv
package dport_pkg;
  typedef enum logic [1:0] {
    XS_DONE    = 2'd0,
    XS_NOMORE  = 2'd1,
    XS_UNKNOWN = 2'd2,
    XS_TIMEOUT = 2'd3
  } xfer_status_e;
endpackage

// File: rtl/dport_watchdog.sv
module dport_watchdog #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int TW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;

  // expired is high during the cycle whose closing edge is the LIMIT-th sample edge
  assign expired = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (run && !expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dport_addr_step.sv
module dport_addr_step #(
  parameter int AW = 16,
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  input  logic          inc_mode,
  input  logic          advance,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [CW-1:0] rem_q;
  logic          inc_q;

  assign last = (rem_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      rem_q <= '0;
      inc_q <= 1'b0;
    end else if (load) begin
      addr  <= base;
      rem_q <= count;
      inc_q <= inc_mode;
    end else if (advance) begin
      rem_q <= rem_q - 1'b1;
      if (inc_q) addr <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/dport_burst_master.sv
module dport_burst_master
  import dport_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int LW      = 16,
  parameter int TIMEOUT = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [DW-1:0] req_wdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_dready,
  input  logic          bus_wack,
  input  logic          bus_nomore,
  input  logic          bus_unknown,
  output logic          bus_timeout,
  output logic          word_valid,
  output logic [1:0]    word_status,
  output logic [DW-1:0] word_rdata,
  output logic          done,
  output logic [1:0]    done_status,
  output logic [LW-2:0] done_count
);
  localparam int CW = LW - 1;

  typedef enum logic [1:0] {M_IDLE, M_WAIT, M_GAP} mstate_e;

  mstate_e       state_q;
  logic          is_wr_q;
  logic [CW-1:0] ok_cnt_q;
  logic          accept, zero_len, load, advance, last, expired;
  logic          hit_ok;
  logic          strobe_now;

  assign req_ready  = (state_q == M_IDLE);
  assign accept     = req_ready && req_valid;
  assign zero_len   = (req_len[CW-1:0] == '0);
  assign load       = accept && !zero_len;
  assign hit_ok     = is_wr_q ? bus_wack : bus_dready;
  assign advance    = (state_q == M_WAIT) && hit_ok;
  assign strobe_now = load || (state_q == M_GAP);
  assign done_count = ok_cnt_q;

  dport_addr_step #(.AW(AW), .CW(CW)) u_addr (
    .clk(clk), .rst(rst), .load(load), .base(req_addr),
    .count(req_len[CW-1:0]), .inc_mode(req_len[LW-1]),
    .advance(advance), .addr(bus_addr), .last(last)
  );

  dport_watchdog #(.LIMIT(TIMEOUT)) u_wdog (
    .clk(clk), .rst(rst), .clear(strobe_now),
    .run(state_q == M_WAIT), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= M_IDLE;
      is_wr_q     <= 1'b0;
      ok_cnt_q    <= '0;
      bus_rd      <= 1'b0;
      bus_wr      <= 1'b0;
      bus_wdata   <= '0;
      bus_timeout <= 1'b0;
      word_valid  <= 1'b0;
      word_status <= XS_DONE;
      word_rdata  <= '0;
      done        <= 1'b0;
      done_status <= XS_DONE;
    end else begin
      bus_rd      <= 1'b0;
      bus_wr      <= 1'b0;
      bus_timeout <= 1'b0;
      word_valid  <= 1'b0;
      done        <= 1'b0;
      if (strobe_now) begin
        bus_rd    <= accept ? !req_write : !is_wr_q;
        bus_wr    <= accept ? req_write : is_wr_q;
        bus_wdata <= req_wdata;
      end
      unique case (state_q)
        M_IDLE: if (accept) begin
          is_wr_q  <= req_write;
          ok_cnt_q <= '0;
          if (zero_len) begin
            done        <= 1'b1;
            done_status <= XS_DONE;
          end else begin
            state_q <= M_WAIT;
          end
        end
        M_WAIT: begin
          if (hit_ok) begin
            word_valid  <= 1'b1;
            word_status <= XS_DONE;
            word_rdata  <= bus_rdata;
            ok_cnt_q    <= ok_cnt_q + 1'b1;
            if (last) begin
              done        <= 1'b1;
              done_status <= XS_DONE;
              state_q     <= M_IDLE;
            end else begin
              state_q <= M_GAP;
            end
          end else if (bus_nomore || bus_unknown || expired) begin
            word_valid  <= 1'b1;
            done        <= 1'b1;
            state_q     <= M_IDLE;
            bus_timeout <= !bus_nomore && !bus_unknown;
            word_status <= bus_nomore ? XS_NOMORE : (bus_unknown ? XS_UNKNOWN : XS_TIMEOUT);
            done_status <= bus_nomore ? XS_NOMORE : (bus_unknown ? XS_UNKNOWN : XS_TIMEOUT);
          end
        end
        M_GAP: state_q <= M_WAIT;
        default: state_q <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dport_burst_master_chk.sv
module dport_burst_master_chk #(
  parameter int TIMEOUT = 32
) (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       bus_timeout,
  input logic       word_valid,
  input logic [1:0] word_status,
  input logic       done,
  input logic [1:0] done_status
);
  logic [7:0] since_strobe;

  always_ff @(posedge clk) begin
    if (rst) since_strobe <= '0;
    else if (bus_rd || bus_wr) since_strobe <= '0;
    else if (since_strobe != 8'hFF) since_strobe <= since_strobe + 1'b1;
  end

  a_r1_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |=> !(bus_rd || bus_wr));
  a_r1_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !(bus_rd || bus_wr));
  a_r5_timeout_window: assert property (@(posedge clk) disable iff (rst)
    bus_timeout |-> (since_strobe == 8'(TIMEOUT - 1)));
  a_r5_timeout_ends: assert property (@(posedge clk) disable iff (rst)
    bus_timeout |-> (done && done_status == 2'd3));
  a_r3_failed_word_ends: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_status != 2'd0) |-> (done && done_status == word_status));
  a_r5_timeout_single: assert property (@(posedge clk) disable iff (rst)
    bus_timeout |=> !bus_timeout);
endmodule

bind dport_burst_master dport_burst_master_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_timeout(bus_timeout), .word_valid(word_valid), .word_status(word_status),
  .done(done), .done_status(done_status)
);

// File: tb/test_dport_burst_master.sv
module test_dport_burst_master;
  localparam int T_OK = 0, T_NOMORE = 1, T_UNKNOWN = 2, T_SILENT = 3, T_WRONG = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_len = '0;
  logic [31:0] req_wdata = '0, bus_rdata = '0;
  logic        bus_dready = 1'b0, bus_wack = 1'b0, bus_nomore = 1'b0, bus_unknown = 1'b0;
  logic        req_ready, bus_rd, bus_wr, bus_timeout, word_valid, done;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, word_rdata;
  logic [1:0]  word_status, done_status;
  logic [14:0] done_count;

  always #2.5 clk = ~clk;

  dport_burst_master i_dport_burst_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_dready(bus_dready), .bus_wack(bus_wack),
    .bus_nomore(bus_nomore), .bus_unknown(bus_unknown), .bus_timeout(bus_timeout),
    .word_valid(word_valid), .word_status(word_status), .word_rdata(word_rdata),
    .done(done), .done_status(done_status), .done_count(done_count)
  );

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  int plan_type[16], plan_delay[16];
  logic [15:0] st_addr[16];
  logic [31:0] st_wd[16];
  int st_cyc[16];
  int sn = 0, cur = 0, dcnt = 0;
  bit pend = 0;
  int wv_n = 0, to_n = 0, to_cyc = 0;
  logic [1:0] wv_stat[16];
  logic [31:0] wv_data[16];
  bit done_seen = 0;
  logic [1:0] d_stat;
  logic [14:0] d_cnt;
  logic [31:0] burst_id = 0;

  function automatic logic [31:0] wfun(int i);
    return 32'h1357_0000 ^ (32'(i) * 32'h9E37_79B1) ^ burst_id;
  endfunction
  function automatic logic [31:0] rfun(logic [15:0] a, int i);
    return {a, 16'hC300 ^ 16'(i)};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 150000) begin
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // bus slave model
  always @(negedge clk) begin
    bus_dready = 0; bus_wack = 0; bus_nomore = 0; bus_unknown = 0;
    if (bus_rd || bus_wr) begin
      if (sn < 16) begin st_addr[sn] = bus_addr; st_wd[sn] = bus_wdata; st_cyc[sn] = cyc; end
      cur = sn; sn++; pend = 1; dcnt = 0;
    end
    if (pend && cur < 16) begin
      if (dcnt == plan_delay[cur]) begin
        pend = 0;
        case (plan_type[cur])
          T_OK: begin
            if (bus_wr_seen()) bus_wack = 1; else bus_dready = 1;
            bus_rdata = rfun(st_addr[cur], cur);
          end
          T_NOMORE:  bus_nomore = 1;
          T_UNKNOWN: bus_unknown = 1;
          T_WRONG:   if (bus_wr_seen()) bus_dready = 1; else bus_wack = 1;
          default: ;
        endcase
      end else dcnt++;
    end
  end

  bit cur_is_wr = 0;
  function automatic bit bus_wr_seen();
    return cur_is_wr;
  endfunction

  // upstream monitor
  always @(negedge clk) begin
    if (word_valid) begin
      if (wv_n < 16) begin wv_stat[wv_n] = word_status; wv_data[wv_n] = word_rdata; end
      wv_n++;
      req_wdata = wfun(wv_n);
    end
    if (done) begin done_seen = 1; d_stat = done_status; d_cnt = done_count; end
    if (bus_timeout) begin to_n++; to_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_burst(input bit wr, input logic [15:0] addr, input int len, input bit inc);
    int n_ok = 0, exp_strobes, guard = 0;
    logic [1:0] exp_stat = 2'd0;
    bit stopped = 0;
    for (int i = 0; i < len && !stopped; i++) begin
      if (plan_type[i] == T_OK) n_ok++;
      else begin
        stopped = 1;
        case (plan_type[i])
          T_NOMORE:  exp_stat = 2'd1;
          T_UNKNOWN: exp_stat = 2'd2;
          default:   exp_stat = 2'd3;
        endcase
      end
    end
    exp_strobes = stopped ? n_ok + 1 : len;
    burst_id = burst_id + 32'h0101_0101;
    @(negedge clk);
    sn = 0; wv_n = 0; to_n = 0; done_seen = 0; pend = 0; cur_is_wr = wr;
    req_valid = 1; req_write = wr; req_addr = addr; req_len = {inc, 15'(len)};
    req_wdata = wfun(0);
    @(negedge clk);
    req_valid = 0;
    #1;
    if (len == 0) chk(done_seen == 1, "R9 zero length done next cycle", 32'(done_seen), 1);
    while (!done_seen && guard < 3000) begin @(negedge clk); #1; guard++; end
    repeat (3) @(negedge clk);
    #1;
    chk(done_seen == 1, "R6 request finished", 32'(done_seen), 1);
    chk(d_stat == exp_stat, "R3 R4 R5 R6 final status", 32'(d_stat), 32'(exp_stat));
    chk(d_cnt == 15'(n_ok), "R8 completed word count", 32'(d_cnt), 32'(n_ok));
    chk(sn == exp_strobes, "R1 R6 strobe count", 32'(sn), 32'(exp_strobes));
    chk(wv_n == exp_strobes, "R8 word reports", 32'(wv_n), 32'(exp_strobes));
    chk(req_ready == 1, "R3 ready for retry", 32'(req_ready), 1);
    for (int i = 0; i < sn && i < 16; i++) begin
      logic [15:0] ea = inc ? 16'(addr + 16'(i)) : addr;
      chk(st_addr[i] == ea, "R7 word address", 32'(st_addr[i]), 32'(ea));
      if (wr) chk(st_wd[i] == wfun(i), "R1 write data", st_wd[i], wfun(i));
      if (i < wv_n && i < n_ok) begin
        chk(wv_stat[i] == 2'd0, "R2 word completed", 32'(wv_stat[i]), 0);
        if (!wr) chk(wv_data[i] == rfun(ea, i), "R2 read data captured", wv_data[i], rfun(ea, i));
      end
    end
    if (exp_stat == 2'd3) begin
      chk(to_n == 1, "R5 one timeout pulse", 32'(to_n), 1);
      if (sn > 0 && sn <= 16)
        chk(to_cyc - st_cyc[sn-1] == 32, "R5 timeout latency", 32'(to_cyc - st_cyc[sn-1]), 32);
    end else begin
      chk(to_n == 0, "R5 no timeout", 32'(to_n), 0);
    end
  endtask

  task automatic set_plan(input int t, input int d);
    for (int i = 0; i < 16; i++) begin plan_type[i] = t; plan_delay[i] = d; end
  endtask

  initial begin
    void'($urandom(32'd2024));
    set_plan(T_OK, 0);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    chk(req_ready == 1 && bus_rd == 0 && bus_wr == 0 && done == 0 && bus_timeout == 0,
        "R10 reset state", {req_ready, bus_rd, bus_wr, done, bus_timeout}, 32'h10);

    set_plan(T_OK, 0); plan_delay[1] = 2; plan_delay[2] = 5;
    run_burst(0, 16'h0040, 3, 1);
    set_plan(T_OK, 1);
    run_burst(1, 16'h8100, 4, 0);
    run_burst(0, 16'h1234, 0, 1);
    set_plan(T_OK, 1); plan_type[2] = T_NOMORE;
    run_burst(0, 16'h9000, 5, 1);
    set_plan(T_OK, 0); plan_type[1] = T_UNKNOWN;
    run_burst(1, 16'h00C8, 3, 1);
    set_plan(T_OK, 0); plan_type[1] = T_SILENT;
    run_burst(0, 16'h8800, 2, 0);
    set_plan(T_WRONG, 3);
    run_burst(0, 16'h8004, 1, 0);
    run_burst(1, 16'h8008, 1, 0);
    set_plan(T_OK, 2);
    run_burst(1, 16'hFFFC, 8, 1);
    set_plan(T_OK, 31);
    run_burst(0, 16'h8020, 2, 1);
    set_plan(T_OK, 0); plan_type[0] = T_NOMORE;
    run_burst(0, 16'h8030, 1, 0);

    for (int b = 0; b < 40; b++) begin
      int len = $urandom % 7;
      for (int i = 0; i < 16; i++) begin
        int r = $urandom % 10;
        plan_type[i] = (r < 7) ? T_OK : (r == 7) ? T_NOMORE : (r == 8) ? T_UNKNOWN : T_SILENT;
        plan_delay[i] = $urandom % 6;
      end
      run_burst(1'($urandom), 16'($urandom), len, 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule